// File: doc/BRIEF.md
# Vectored Interrupt Controller with Stack Guard

This block arbitrates interrupt requests for a small 8-bit microcontroller core. Three sources feed it: a USB event line (any of host buffer access, bus suspend, bus resume or bus reset), the overflow of timer 0 and the overflow of timer 1. Each source owns a sticky pending flag and an enable bit. All of them sit in a single control register that firmware writes and reads. A global enable bit gates every source at once.

When a request is pending and enabled, the global enable is set and the core reports that its return stack has room, the controller issues a one-cycle acknowledge together with the vector address. The core then pushes its program counter and branches to that vector. Only the program counter is saved, so firmware must save any other context itself.

Entry clears the global enable and the serviced flag. Further requests then stay pending until firmware sets the global enable again, and setting it inside a handler is what allows nesting. A wake-up output tells the clock control logic that a request is pending, so that a halted core resumes.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After synchronous reset the control register reads 0x00, and `irq_ack`, `irq_vector` and `wake` are 0.
- R2: The control register layout is: bit 0 global enable; bits 1, 2, 3 enable USB, timer 0, timer 1; bits 4, 5, 6 are the USB, timer 0, timer 1 pending flags; bit 7 reads 0. A write replaces bits 0 to 6 and the new value is visible on `reg_rdata` in the next cycle.
- R3: A pulse on any `usb_evt` line sets flag bit 4, and a pulse on `tmr_ovf[0]` or `tmr_ovf[1]` sets flag bit 5 or bit 6. This happens in the cycle after the pulse, whatever the enables are.
- R4: `irq_ack` rises for exactly one cycle, one cycle after a flag, its enable, the global enable and a low `stack_full` are all present together. It never rises while the source enable or the global enable is clear.
- R5: With `irq_ack` high, `irq_vector` is 0x04 for USB, 0x08 for timer 0 and 0x0C for timer 1. With `irq_ack` low, `irq_vector` is 0.
- R6: In the cycle `irq_ack` is high, the global enable and the serviced flag already read 0, and every other bit is unchanged.
- R7: While the global enable is clear, new events still set their flags. Those flags are acknowledged once firmware sets the global enable.
- R8: While `stack_full` is high, no acknowledge is issued. The request stays pending and is acknowledged after `stack_full` falls.
- R9: When several requests are eligible in the same cycle, USB is served first, then timer 0, then timer 1.
- R10: `wake` is high exactly when at least one pending flag is set, regardless of the enable bits.
- R11: An event arriving on the cycle its flag is cleared by entry leaves the flag set. The entry clearing of the global enable and of the serviced flag wins over a register write in the same cycle.
- R12: Setting the global enable again after an acknowledge lets another pending, enabled request be acknowledged, which is how nesting works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_evt | input | 4 | USB event pulses (buffer access, suspend, resume, bus reset) |
| tmr_ovf | input | 2 | Timer 0 and timer 1 overflow pulses |
| stack_full | input | 1 | Core return stack is full |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| irq_ack | output | 1 | One-cycle acknowledge: push PC and branch |
| irq_vector | output | 8 | Branch target, valid with `irq_ack` |
| wake | output | 1 | A request is pending, release HALT |

## Verification
The bench builds the block with its default parameters: four USB event lines, two timers, an 8-bit register, vector base 0x04 and a vector step of 4. These values produce exactly the three vectors and the register layout the requirements name, so every bit position and vector value can be checked against fixed numbers.

Pulses arriving in the same cycle reach the priority order. Holding the stack-full input and clearing the enables reach the blocking paths. Driving an event, or a register write, into the one cycle in which the controller is deciding an acknowledge reaches the two precedence rules on the same flops.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  // Fixed register positions shared by the controller and its checker.
  localparam int GIE_BIT = 0;
  localparam int EN_LSB  = 1;

  // Source index, also the arbitration rank (lower wins).
  typedef enum int {
    SRC_USB  = 0,
    SRC_TMR0 = 1,
    SRC_TMR1 = 2
  } ivc_src_e;
endpackage

// File: rtl/ivc_flag_bank.sv
module ivc_flag_bank #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wr_flags,
  input  logic [NUM_SRC-1:0] entry_clr,
  output logic [NUM_SRC-1:0] flags_q
);
  // Precedence per flag: event set, then entry clear, then firmware write.
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                flags_q[gi] <= 1'b0;
      else if (evt[gi])       flags_q[gi] <= 1'b1;
      else if (entry_clr[gi]) flags_q[gi] <= 1'b0;
      else if (wr_en)         flags_q[gi] <= wr_flags[gi];
    end
  end
endmodule

// File: rtl/ivc_enable_reg.sv
module ivc_enable_reg #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_gie,
  input  logic [NUM_SRC-1:0] wr_src_en,
  input  logic               entry,
  output logic               gie_q,
  output logic [NUM_SRC-1:0] src_en_q
);
  // Entry drops the global enable and beats a concurrent write.
  always_ff @(posedge clk) begin
    if (rst)         gie_q <= 1'b0;
    else if (entry)  gie_q <= 1'b0;
    else if (wr_en)  gie_q <= wr_gie;
  end

  always_ff @(posedge clk) begin
    if (rst)        src_en_q <= '0;
    else if (wr_en) src_en_q <= wr_src_en;
  end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
  parameter int NUM_SRC  = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic [NUM_SRC-1:0] req,
  output logic [NUM_SRC-1:0] grant,
  output logic               any,
  output logic [VEC_W-1:0]   vec
);
  // Fixed priority: index 0 highest.
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_rank
    if (gi == 0) begin : g_top
      assign grant[gi] = req[gi];
    end else begin : g_low
      assign grant[gi] = req[gi] & ~(|req[gi-1:0]);
    end
  end

  assign any = |req;

  always_comb begin
    vec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) vec = vec | VEC_W'(VEC_BASE + i * VEC_STEP);
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int USB_EVT_N = 4,
  parameter int NUM_TMR   = 2,
  parameter int REG_W     = 8,
  parameter int VEC_W     = 8,
  parameter int VEC_BASE  = 4,
  parameter int VEC_STEP  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [USB_EVT_N-1:0] usb_evt,
  input  logic [NUM_TMR-1:0]   tmr_ovf,
  input  logic                 stack_full,
  input  logic                 reg_we,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 irq_ack,
  output logic [VEC_W-1:0]     irq_vector,
  output logic                 wake
);
  import ivc_pkg::*;

  localparam int NUM_SRC  = 1 + NUM_TMR;
  localparam int FLAG_LSB = EN_LSB + NUM_SRC;
  localparam int USED_W   = FLAG_LSB + NUM_SRC;

  logic [NUM_SRC-1:0] src_evt;
  logic [NUM_SRC-1:0] flags_q;
  logic [NUM_SRC-1:0] src_en_q;
  logic               gie_q;
  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] grant;
  logic               grant_any;
  logic [VEC_W-1:0]   grant_vec;
  logic               ack_q;
  logic [VEC_W-1:0]   vec_q;

  // Any USB condition raises the single USB request.
  assign src_evt[SRC_USB]       = |usb_evt;
  assign src_evt[NUM_SRC-1:1]   = tmr_ovf;

  ivc_flag_bank #(.NUM_SRC(NUM_SRC)) flags_i (
    .clk       (clk),
    .rst       (rst),
    .evt       (src_evt),
    .wr_en     (reg_we),
    .wr_flags  (reg_wdata[FLAG_LSB +: NUM_SRC]),
    .entry_clr (grant),
    .flags_q   (flags_q)
  );

  ivc_enable_reg #(.NUM_SRC(NUM_SRC)) enables_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_we),
    .wr_gie    (reg_wdata[GIE_BIT]),
    .wr_src_en (reg_wdata[EN_LSB +: NUM_SRC]),
    .entry     (grant_any),
    .gie_q     (gie_q),
    .src_en_q  (src_en_q)
  );

  // Stack guard: nothing is eligible while the core cannot push.
  assign eligible = (gie_q && !stack_full) ? (flags_q & src_en_q) : '0;

  ivc_arbiter #(
    .NUM_SRC  (NUM_SRC),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) arb_i (
    .req   (eligible),
    .grant (grant),
    .any   (grant_any),
    .vec   (grant_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= grant_any;
      vec_q <= grant_any ? grant_vec : '0;
    end
  end

  assign irq_ack    = ack_q;
  assign irq_vector = vec_q;
  assign wake       = |flags_q;
  assign reg_rdata  = REG_W'({flags_q, src_en_q, gie_q});

  if (REG_W > USED_W) begin : g_spare
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[REG_W-1:USED_W];
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_SRC  = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               stack_full,
  input logic               irq_ack,
  input logic [VEC_W-1:0]   irq_vector,
  input logic               wake,
  input logic               gie_bit,
  input logic [NUM_SRC-1:0] flag_bits
);
  localparam int VEC_TOP = VEC_BASE + (NUM_SRC - 1) * VEC_STEP;

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);

  a_r4_needs_gie: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> $past(gie_bit));

  a_r6_gie_dropped: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> !gie_bit);

  a_r8_stack_blocks: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> !$past(stack_full));

  a_r5_idle_vector: assert property (@(posedge clk) disable iff (rst)
    !irq_ack |-> (irq_vector == '0));

  a_r5_vector_range: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (int'(irq_vector) >= VEC_BASE && int'(irq_vector) <= VEC_TOP));

  a_r10_wake_pending: assert property (@(posedge clk) disable iff (rst)
    wake == (flag_bits != '0));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .NUM_SRC  (1 + NUM_TMR),
  .VEC_W    (VEC_W),
  .VEC_BASE (VEC_BASE),
  .VEC_STEP (VEC_STEP)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .stack_full (stack_full),
  .irq_ack    (irq_ack),
  .irq_vector (irq_vector),
  .wake       (wake),
  .gie_bit    (reg_rdata[0]),
  .flag_bits  (reg_rdata[2 + NUM_TMR +: 1 + NUM_TMR])
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] usb_evt = '0;
  logic [1:0] tmr_ovf = '0;
  logic       stack_full = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_ack;
  logic [7:0] irq_vector;
  logic       wake;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst(rst), .usb_evt(usb_evt), .tmr_ovf(tmr_ovf),
    .stack_full(stack_full), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_vector(irq_vector),
    .wake(wake)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: every acknowledge must match the next expected vector.
  always @(negedge clk) begin
    if (!rst && !done && irq_ack) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4: actual ack vector 0x%0h expected no ack", irq_vector);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (irq_vector != e) begin
          fails++;
          $display("FAIL R5: actual vector 0x%0h expected 0x%0h", irq_vector, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] u, input logic [1:0] t);
    usb_evt = u; tmr_ovf = t;
    @(negedge clk);
    usb_evt = '0; tmr_ovf = '0;
  endtask

  task automatic expect_ack(input logic [7:0] v);
    exp_q.push_back(v);
  endtask

  task automatic drained(input string req);
    check(req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 reg", reg_rdata, 8'h00);
    check("R1 ack", irq_ack, 0);
    check("R1 vector", irq_vector, 0);
    check("R1 wake", wake, 0);

    // R2 layout, bit 7 reads zero
    wr(8'h8E);
    check("R2 readback", reg_rdata, 8'h0E);
    // R10 flags set by write, enables off: wake without ack
    wr(8'h70);
    check("R2 flags", reg_rdata, 8'h70);
    check("R10 wake", wake, 1);
    idle(3);
    drained("R4 no ack gie clear");
    wr(8'h00);
    check("R10 wake low", wake, 0);

    // R3 / R7: events pend while gie clear
    wr(8'h0E);
    pulse(4'b0000, 2'b01);
    check("R3 tmr0 flag", reg_rdata, 8'h2E);
    pulse(4'b0100, 2'b00);
    check("R3 usb flag", reg_rdata, 8'h3E);
    idle(3);
    drained("R7 pending no ack");
    // R7 / R9 / R6: enable, USB first
    expect_ack(8'h04);
    wr(8'h3F);
    idle(3);
    drained("R7 usb served");
    check("R6 after usb", reg_rdata, 8'h2E);
    // R12 nesting
    expect_ack(8'h08);
    wr(8'h2F);
    idle(3);
    drained("R12 nested tmr0");
    check("R12 after tmr0", reg_rdata, 8'h0E);

    // R8 stack guard
    stack_full = 1'b1;
    pulse(4'b0000, 2'b10);
    wr(8'h4F);
    idle(5);
    drained("R8 blocked");
    check("R8 still pending", reg_rdata, 8'h4F);
    expect_ack(8'h0C);
    stack_full = 1'b0;
    idle(3);
    drained("R8 released");
    check("R8 after tmr1", reg_rdata, 8'h0E);

    // R4 enable gating
    wr(8'h01);
    pulse(4'b0000, 2'b01);
    idle(4);
    drained("R4 disabled source");
    check("R4 pending", reg_rdata, 8'h21);
    expect_ack(8'h08);
    wr(8'h25);
    idle(3);
    drained("R4 enabled source");
    check("R4 after", reg_rdata, 8'h04);

    // R9 simultaneous requests
    wr(8'h0F);
    expect_ack(8'h04);
    pulse(4'b0001, 2'b11);
    idle(3);
    drained("R9 usb first");
    check("R9 remaining", reg_rdata, 8'h6E);
    expect_ack(8'h08);
    wr(8'h6F);
    idle(3);
    drained("R9 tmr0 second");
    check("R9 remaining2", reg_rdata, 8'h4E);
    expect_ack(8'h0C);
    wr(8'h4F);
    idle(3);
    drained("R9 tmr1 last");
    check("R9 empty", reg_rdata, 8'h0E);

    // R11 event during entry keeps flag
    wr(8'h0F);
    expect_ack(8'h04);
    pulse(4'b0010, 2'b00);
    pulse(4'b1000, 2'b00);
    idle(3);
    drained("R11 event vs clear");
    check("R11 flag kept", reg_rdata, 8'h1E);
    check("R11 wake", wake, 1);
    wr(8'h0E);
    // R11 entry clear beats write
    wr(8'h0F);
    expect_ack(8'h08);
    pulse(4'b0000, 2'b01);
    wr(8'h2F);
    idle(3);
    drained("R11 write vs clear");
    check("R11 clear wins", reg_rdata, 8'h0E);

    idle(2);
    drained("R4 final");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule